// File: doc/BRIEF.md
# Prefetching Instruction Line Cache

This block sits between the instruction fetch stage of one processor core and a shared, time-slotted memory that returns data one 32-bit word at a time. It keeps four lines of eight words each. Any of the four lines may hold any line address. A fetch that finds its word resident is answered in the same clock. A fetch that misses holds the core until the memory delivers that word.

When the core is running from a resident line and the following line is absent, the cache fetches that following line on its own, with no request from the core. Straight-line code therefore finds the next line already arriving or complete when it crosses a line boundary. Words of a line that is still filling are served as soon as they have arrived, so the core does not wait for the whole line.

The memory side has three parts. The cache raises a request and presents a line address. The memory returns words with a valid strobe and a word index, at the times its slots allow. A strobe always belongs to the line address presented in the same cycle. If the cache changes the presented line address, the memory starts over on the new line.

Top module: `icache_prefetch`

## Requirements
- R1: After reset no line is valid, `mem_req` is low and `fetch_ready` is low. The first fetch misses.
- R2: A fetch whose line is resident raises `fetch_ready` in the same cycle, with the stored word on `fetch_data`. The core is not stalled.
- R3: A fetch that misses while no fill is running starts a fill at the next clock edge. The fill drives `mem_req` high and puts the fetch address without its low three bits on `mem_line`. `fetch_ready` stays low until the memory strobes `mem_wvalid` with `mem_widx` equal to the low three address bits, and rises in that same cycle with `mem_wdata` forwarded.
- R4: While a line is filling, a fetch of any word of that line that has already arrived, or that is arriving in the same cycle, is answered without stall.
- R5: While no fill is running, a fetch that hits a resident line starts a fill of the next line address at the next edge, provided that line is absent. That fill drives `mem_req` high with `mem_line` equal to the current line address plus one.
- R6: No fill is started when the next line address is already resident.
- R7: A missing fetch to a line other than the one being filled abandons the running fill. At the next edge `mem_line` changes to the new line, and `mem_req` stays high.
- R8: A new fill replaces lines in rotating order, starting from line slot 0. A fill started ahead of the core skips the slot the core is currently hitting. A fill that abandons another reuses that fill's slot.
- R9: A one-cycle `flush` invalidates all lines, drops any running fill so that `mem_req` is low after the next edge, and restarts the rotation at slot 0.
- R10: Once ahead-of-time fills are running, sequential fetches across several line boundaries proceed one per clock with no stall, for a memory that returns the first word two cycles after the request is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all lines and drop any fill |
| fetch_req | input | 1 | Core requests an instruction word |
| fetch_addr | input | AW | Word address of the fetch |
| fetch_ready | output | 1 | Fetch answered this cycle |
| fetch_data | output | WW | Instruction word |
| mem_req | output | 1 | A line fill is in progress |
| mem_line | output | AW-3 | Line address being filled |
| mem_wvalid | input | 1 | Memory delivers one word this cycle |
| mem_widx | input | 3 | Index of the delivered word within the line |
| mem_wdata | input | WW | Delivered word |

## Verification
The hardest state to reach is the one where the rotating replacement pointer lands on the very slot the core is executing from, at the moment a fill ahead of the core is about to start. If the skip rule is wrong, the running line is evicted and the core starts to thrash. The stimulus reaches this state after a flush: four whole lines are filled on demand, one after another, so the pointer wraps back to slot 0. The core then re-enters the line in slot 0, and stall counts and data show whether that line survived. Abandoned fills are reached by branching to a far line while a fill is still in flight. The memory model restarts on every line change, so each stall count is exact.

// File: rtl/icache_prefetch.sv
module icache_prefetch #(
  parameter int AW   = 16,
  parameter int WW   = 32,
  parameter int WAYS = 4,
  parameter int WPL  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       fetch_req,
  input  logic [AW-1:0]              fetch_addr,
  output logic                       fetch_ready,
  output logic [WW-1:0]              fetch_data,
  output logic                       mem_req,
  output logic [AW-$clog2(WPL)-1:0]  mem_line,
  input  logic                       mem_wvalid,
  input  logic [$clog2(WPL)-1:0]     mem_widx,
  input  logic [WW-1:0]              mem_wdata
);
  localparam int OB    = $clog2(WPL);
  localparam int LW    = AW - OB;
  localparam int IB    = $clog2(WAYS);
  localparam int DEPTH = WAYS * WPL;

  logic [WW-1:0]   data_q [DEPTH];
  logic [LW-1:0]   tag_q  [WAYS];
  logic [WAYS-1:0] vld_q, hit_vec, nxt_vec;
  logic [IB-1:0]   rr_q, fill_way_q, hit_way, victim;
  logic            busy_q;
  logic [LW-1:0]   fill_line_q, new_line;
  logic [WPL-1:0]  mask_q, mask_nx;

  logic [LW-1:0] req_line, nxt_line;
  logic [OB-1:0] req_word;
  logic any_hit, fill_match, part_hit, fwd, wr_en, miss_start, pref_start;

  assign req_line = fetch_addr[AW-1:OB];
  assign req_word = fetch_addr[OB-1:0];
  assign nxt_line = req_line + LW'(1);

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      hit_vec[i] = vld_q[i] && (tag_q[i] == req_line);
      nxt_vec[i] = vld_q[i] && (tag_q[i] == nxt_line);
      if (hit_vec[i]) hit_way = IB'(i);
    end
  end

  assign any_hit    = |hit_vec;
  assign fill_match = busy_q && (fill_line_q == req_line);
  assign part_hit   = fill_match && mask_q[req_word];
  assign fwd        = fill_match && mem_wvalid && (mem_widx == req_word);

  assign fetch_ready = fetch_req && (any_hit || part_hit || fwd);
  assign fetch_data  = any_hit  ? data_q[{hit_way, req_word}] :
                       part_hit ? data_q[{fill_way_q, req_word}] : mem_wdata;

  assign miss_start = fetch_req && !fetch_ready && !fill_match && !flush;
  assign pref_start = fetch_req && any_hit && !busy_q && !(|nxt_vec) && !flush;
  assign new_line   = miss_start ? req_line : nxt_line;

  always_comb begin
    if (busy_q)                             victim = fill_way_q;
    else if (pref_start && rr_q == hit_way) victim = rr_q + 1'b1;
    else                                    victim = rr_q;
  end

  assign wr_en   = busy_q && mem_wvalid;
  assign mask_nx = mask_q | (wr_en ? (WPL'(1) << mem_widx) : '0);

  assign mem_req  = busy_q;
  assign mem_line = fill_line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q       <= '0;
      busy_q      <= 1'b0;
      rr_q        <= '0;
      fill_way_q  <= '0;
      fill_line_q <= '0;
      mask_q      <= '0;
      for (int i = 0; i < WAYS; i++) tag_q[i] <= '0;
    end else if (flush) begin
      vld_q  <= '0;
      busy_q <= 1'b0;
      rr_q   <= '0;
      mask_q <= '0;
    end else begin
      if (wr_en) begin
        mask_q <= mask_nx;
        if (&mask_nx) begin
          vld_q[fill_way_q] <= 1'b1;
          busy_q            <= 1'b0;
        end
      end
      if (miss_start || pref_start) begin
        tag_q[victim] <= new_line;
        vld_q[victim] <= 1'b0;
        busy_q        <= 1'b1;
        fill_line_q   <= new_line;
        fill_way_q    <= victim;
        mask_q        <= '0;
        if (!busy_q) rr_q <= victim + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[{fill_way_q, mem_widx}] <= mem_wdata;
  end

  p_unique_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0) && !mem_req);

  p_abort_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ready && mem_req && (mem_line != req_line) && !flush)
    |=> mem_req && (mem_line == $past(req_line)));

  p_ahead_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && any_hit && !mem_req && !(|nxt_vec) && !flush)
    |=> mem_req && (mem_line == LW'($past(req_line) + LW'(1))));

  p_no_redundant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ready && !mem_req && (|nxt_vec) && !flush) |=> !mem_req);

  p_ready_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && !any_hit) |-> mem_req);
endmodule

// File: tb/icache_prefetch_bench.sv
`timescale 1ns/1ps
module icache_prefetch_bench;
  localparam int LAT = 2;
  localparam int N   = 12;

  // runs: start address, length, stall of first fetch, stall of later fetches (-1 = any), flush before
  localparam logic [15:0] RA [N] = '{16'h0200, 16'h0200, 16'h0300, 16'h0204, 16'h0310, 16'h0200,
                                     16'h0500, 16'h0520, 16'h0540, 16'h0560, 16'h0500, 16'h0520};
  localparam int RL [N] = '{8, 24, 8, 4, 1, 8, 8, 8, 8, 8, 16, 8};
  localparam int S0 [N] = '{3, 0, 3, 0, 3, 3, 3, 3, 3, 3, 0, 3};
  localparam int S1 [N] = '{0, 0, 0, 0, -1, 0, 0, 0, 0, 0, 0, 0};
  localparam bit RF [N] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0};
  // R3 cold miss, R10 sustained, R7 abort, R2 hits, R3 miss, R8 eviction,
  // R9 after flush, R4 fills, R8 pointer skip and its victim
  localparam logic [23:0] RT [N] = '{"R3", "R10", "R7", "R2", "R3", "R8",
                                     "R9", "R4", "R4", "R4", "R8", "R8"};

  logic clk = 0, rst_n = 0, flush = 0, fetch_req = 0;
  logic [15:0] fetch_addr = '0;
  logic fetch_ready, mem_req, mem_wvalid = 0;
  logic [31:0] fetch_data, mem_wdata = '0;
  logic [12:0] mem_line;
  logic [2:0] mem_widx = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  icache_prefetch u_icache_prefetch (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_data(fetch_data),
    .mem_req(mem_req), .mem_line(mem_line),
    .mem_wvalid(mem_wvalid), .mem_widx(mem_widx), .mem_wdata(mem_wdata));

  function automatic logic [31:0] word_of(input logic [15:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  logic [12:0] m_last = '0;
  bit m_have = 0;
  int m_cnt = 0;
  always @(negedge clk) begin
    if (!mem_req) begin
      m_have = 0; mem_wvalid = 0;
    end else begin
      if (!m_have || mem_line != m_last) begin
        m_last = mem_line; m_have = 1; m_cnt = 0;
      end
      if (m_cnt >= LAT && m_cnt < LAT + 8) begin
        mem_wvalid = 1;
        mem_widx   = 3'(m_cnt - LAT);
        mem_wdata  = word_of({m_last, mem_widx});
      end else mem_wvalid = 0;
      m_cnt++;
    end
  end

  task automatic check(input bit ok, input logic [23:0] tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [15:0] a, input int exp_stall, input logic [23:0] tag);
    int stall = 0;
    fetch_req = 1; fetch_addr = a;
    #1;
    while (!fetch_ready && stall < 60) begin
      @(negedge clk); #1; stall++;
    end
    check(fetch_ready && fetch_data == word_of(a), tag, fetch_data, word_of(a));
    if (exp_stall >= 0) check(stall == exp_stall, tag, stall, exp_stall);
    @(negedge clk);
  endtask

  task automatic pulse_flush();
    fetch_req = 0; flush = 1;
    @(negedge clk); flush = 0; #1;
    check(!mem_req, "R9", mem_req, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    check(!mem_req, "R1", mem_req, 0);
    check(!fetch_ready, "R1", fetch_ready, 0);
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      if (RF[i]) pulse_flush();
      for (int k = 0; k < RL[i]; k++)
        do_fetch(RA[i] + 16'(k), (k == 0) ? S0[i] : S1[i], RT[i]);
    end

    // R5 and R6: launch of a fill ahead of the core, and its suppression
    pulse_flush();
    for (int k = 0; k < 8; k++) do_fetch(16'h0600 + 16'(k), k == 0 ? 3 : 0, "R4");
    for (int k = 0; k < 8; k++) do_fetch(16'h0608 + 16'(k), k == 0 ? 3 : 0, "R4");
    do_fetch(16'h0600, 0, "R2");
    fetch_req = 0; #1;
    check(!mem_req, "R6", mem_req, 0);
    @(negedge clk);
    do_fetch(16'h0608, 0, "R2");
    fetch_req = 0; #1;
    check(mem_req, "R5", mem_req, 1);
    check(mem_line == 13'h0C2, "R5", mem_line, 13'h0C2);
    @(negedge clk);
    // R9: flush drops the fill in flight and invalidates resident lines
    pulse_flush();
    do_fetch(16'h0608, 3, "R9");
    fetch_req = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1: watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule